// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when selected transitions occur on up to four asynchronous input lines. A shared timestamp counter runs only while capture is switched on, and a programmable divider sets how fast it advances. Each channel has its own two-bit edge code that picks which transitions it reacts to. When a chosen transition is seen, the channel copies the counter into its own capture register and raises its pending flag. Software sets up the block and reads the results through a simple word-addressed register port. One interrupt line summarises every pending flag whose enable bit is set.

A typical sequence is as follows. Software programs the edge codes and enables, then writes the control word with the divider and the run bit. It waits for the interrupt, reads the status word and the capture values, and clears the flags through the acknowledge register.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, every capture value, edge code, interrupt enable and pending flag reads zero, and `irq` is low.
- R2: Edge codes select the transitions: 0 = none, 1 = low-to-high, 2 = high-to-low, 3 = either. A transition that is not selected leaves the channel's flag and capture value untouched.
- R3: Channel n's capture value reads at address 0x10+4n. A transition on `cap_in[n]` driven before clock edge i, where edge 0 is the edge that writes the run bit to 1, latches floor((i+1)/(D+1)). D is the divider value. The flag is visible after edge i+2.
- R4: Control word at 0x50: the divider is bits 8:4 and the run bit is bit 10. While running, the timestamp rises by exactly one every D+1 clocks.
- R5: While the run bit is 0, the timestamp is held at zero and no transition sets a flag or changes a capture value.
- R6: The interrupt enable word at 0x54 uses bits 1..4 for channels 0..3. `irq` is the OR of the pending flags that are also enabled.
- R7: The status word at 0x58 shows the pending flag of channel n at bit n+1. All other bits read zero.
- R8: A write to 0x5C clears each flag whose bit n+1 is 1 in the written data and leaves the others. Writing 0x1FF clears all flags.
- R9: If a flag is set by a transition on the same edge that an acknowledge clears it, the flag stays set.
- R10: Each new captured transition overwrites the channel's earlier capture value.
- R11: The edge code register of channel n is at 0x30+4n. It keeps only data bits 1:0 and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | NCH | Asynchronous capture inputs |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. A capture value never changes unless its flag is set on the same edge, and a detected transition always leaves its flag set even under an acknowledge. The timestamp stays at zero while the unit is stopped and grows by at most one per clock while it runs. An acknowledged flag with no new transition falls. The exact timestamp values for each divider setting can only be shown by the bench scenarios. The same holds for the per-code edge filtering, the gating of the interrupt by its enable bits, and the readback layout of the registers.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int NCH = 4,
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] cap_in,
  output logic           irq
);
  localparam int PSW = 5;
  localparam logic [7:0] A_CTRL = 8'h50;
  localparam logic [7:0] A_IEN  = 8'h54;
  localparam logic [7:0] A_STAT = 8'h58;
  localparam logic [7:0] A_ACK  = 8'h5C;

  logic [PSW-1:0] div_cfg, div_cnt;
  logic           run;
  logic [TSW-1:0] ts;
  logic [NCH-1:0] ien, stat, evt, ack_hit;
  logic [NCH-1:0] s1, s2, s3;
  logic [1:0]     esel [NCH];
  logic [TSW-1:0] capv [NCH];
  logic           unused_bits;

  assign unused_bits = ^{bus_wdata[31:11], bus_wdata[9]};
  assign ack_hit = (bus_we && bus_addr == A_ACK) ? bus_wdata[NCH:1] : '0;
  assign irq = |(stat & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_cnt <= '0;
      ts      <= '0;
    end else if (div_cnt >= div_cfg) begin
      div_cnt <= '0;
      ts      <= ts + TSW'(1);
    end else begin
      div_cnt <= div_cnt + PSW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cfg <= '0;
      run     <= 1'b0;
      ien     <= '0;
      stat    <= '0;
    end else begin
      if (bus_we && bus_addr == A_CTRL) begin
        div_cfg <= bus_wdata[8:4];
        run     <= bus_wdata[10];
      end
      if (bus_we && bus_addr == A_IEN) ien <= bus_wdata[NCH:1];
      stat <= (stat & ~ack_hit) | evt;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic rise, fall;
    assign rise   = s2[n] & ~s3[n];
    assign fall   = ~s2[n] & s3[n];
    assign evt[n] = run & ((rise & esel[n][0]) | (fall & esel[n][1]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        esel[n] <= 2'd0;
        capv[n] <= '0;
      end else begin
        if (bus_we && bus_addr == 8'(8'h30 + 4*n)) esel[n] <= bus_wdata[1:0];
        if (evt[n]) capv[n] <= ts;
      end
    end

    a_r3_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (capv[n] != $past(capv[n])) |-> stat[n]);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[n] |=> stat[n]);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[n] && !evt[n]) |=> !stat[n]);
    a_r5_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(capv[n]));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[8:4] = div_cfg;
        bus_rdata[10]  = run;
      end
      A_IEN:  bus_rdata[NCH:1] = ien;
      A_STAT: bus_rdata[NCH:1] = stat;
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == 8'(8'h10 + 4*n)) bus_rdata = 32'(capv[n]);
      if (bus_addr == 8'(8'h30 + 4*n)) bus_rdata = {30'd0, esel[n]};
    end
  end

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ts == '0));
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (ts == $past(ts) || ts == $past(ts) + TSW'(1)));
  a_r6_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0));
endmodule

// File: tb/sim_edge_capture_unit.sv
module sim_edge_capture_unit;
  localparam int NCH = 4;
  typedef struct { int ch; int val; } item_t;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] cap_in = '0;
  logic irq;

  int cyc = 0, checks = 0, failures = 0, en_p = 0, ps_m = 0;
  bit run_m = 0, done = 0;
  logic [1:0] esel_m [NCH];
  logic [NCH-1:0] exp_stat = '0;
  int exp_cap [NCH];
  item_t q [$];

  edge_capture_unit #(.NCH(NCH), .TSW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 8'h50) begin
      run_m = d[10]; ps_m = int'(d[8:4]); en_p = cyc + 1;
    end
    if (a == 8'h5C) exp_stat = exp_stat & ~d[NCH:1];
    for (int n = 0; n < NCH; n++) if (a == 8'(8'h30 + 4*n)) esel_m[n] = d[1:0];
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic monitor_drain(input string req);
    int v;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      rd(8'(8'h10 + 4*it.ch), v);
      chk(req, v, it.val);
    end
    rd(8'h58, v);
    chk({req, " status"}, v, int'({exp_stat, 1'b0}));
  endtask

  task automatic drive(input int ch, input logic lvl, input bit drain_now);
    logic old;
    int p;
    @(negedge clk);
    old = cap_in[ch]; p = cyc + 1; cap_in[ch] = lvl;
    if (run_m && ((!old && lvl && esel_m[ch][0]) || (old && !lvl && esel_m[ch][1]))) begin
      q.push_back('{ch, (p + 1 - en_p) / (ps_m + 1)});
      exp_stat[ch] = 1'b1;
      exp_cap[ch] = (p + 1 - en_p) / (ps_m + 1);
    end
    if (drain_now) begin
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic cap_same(input string req, input int ch);
    int v;
    rd(8'(8'h10 + 4*ch), v);
    chk(req, v, exp_cap[ch]);
  endtask

  initial begin
    int v;
    for (int n = 0; n < NCH; n++) begin esel_m[n] = 2'd0; exp_cap[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h58, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);
    rd(8'h10, v); chk("R1 capture", v, 0);
    rd(8'h30, v); chk("R1 edge code", v, 0);
    wr(8'h30, 32'hFFFF_FFFD); rd(8'h30, v); chk("R11 edge code width", v, 1);
    wr(8'h34, 32'd2); wr(8'h38, 32'd3); wr(8'h3C, 32'd0);
    rd(8'h38, v); chk("R11 edge code ch2", v, 3);

    drive(0, 1'b1, 1); monitor_drain("R5 stopped");
    cap_same("R5 capture held", 0);
    drive(0, 1'b0, 1);

    wr(8'h50, 32'h0000_0400);
    rd(8'h50, v); chk("R4 control readback", v, 32'h400);
    repeat (7) @(negedge clk);
    drive(0, 1'b1, 1); monitor_drain("R3 rise ch0");
    drive(1, 1'b1, 1); monitor_drain("R2 unselected rise ch1");
    drive(3, 1'b1, 1); monitor_drain("R2 code zero ch3");
    cap_same("R2 ch3 capture held", 3);
    chk("R6 irq gated off", int'(irq), 0);
    wr(8'h54, 32'h2);
    chk("R6 irq enabled", int'(irq), 1);
    wr(8'h5C, 32'h4); monitor_drain("R8 partial ack");
    chk("R8 irq kept", int'(irq), 1);
    wr(8'h5C, 32'h1FF); monitor_drain("R8 full ack");
    chk("R8 irq cleared", int'(irq), 0);

    repeat (5) @(negedge clk);
    drive(1, 1'b0, 1); monitor_drain("R2 fall ch1");
    drive(2, 1'b1, 1); monitor_drain("R2 both rise ch2");
    repeat (9) @(negedge clk);
    drive(2, 1'b0, 1); monitor_drain("R10 both fall ch2 overwrite");
    drive(0, 1'b0, 1); monitor_drain("R2 fall ignored ch0");
    rd(8'h58, v); chk("R7 status layout", v, 32'h0C);

    wr(8'h50, 32'h0);
    wr(8'h5C, 32'h1FF);
    wr(8'h50, 32'h0000_0430);
    rd(8'h50, v); chk("R4 divider readback", v, 32'h430);
    repeat (6) @(negedge clk);
    drive(2, 1'b1, 1); monitor_drain("R4 divided stamp a");
    repeat (13) @(negedge clk);
    drive(2, 1'b0, 1); monitor_drain("R4 divided stamp b");
    repeat (2) @(negedge clk);
    drive(0, 1'b1, 1); monitor_drain("R4 divided stamp c");

    wr(8'h5C, 32'h2);
    drive(2, 1'b1, 0);
    @(negedge clk);
    wr(8'h5C, 32'h1FF);
    exp_stat[2] = 1'b1;
    repeat (2) @(negedge clk);
    monitor_drain("R9 set beats ack");
    chk("R9 irq from ch2 disabled", int'(irq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule